// File: doc/BRIEF.md
# Cascaded Backplane Sync Sequencer

This block steps the backplane phase of one display driver that may sit in a cascade of drivers sharing a single wired-AND synchronisation line. Every phase tick moves the phase index on by one, wrapping after the number of backplane phases that the selected multiplex ratio calls for. When the driver enters its final active backplane phase, it pulls the shared line low for that whole phase. In every other phase it watches the line.

When another device pulls the line low while this one is out of step, the sequencer jumps straight to its own final phase. The next tick then wraps it to phase 0 together with the device that asserted the line. As a result, the first device to assert the line brings the whole cascade back into step. The pin is modelled as an active-high pull-down enable plus an active-low read-back of the wired line. The external pull-up and the analog waveforms are not part of this block.

Top module: `bpsync_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after its release, `phase_o` is 0 and `sync_oe_o` is 0.
- R2: The multiplex code on `mux_mode_i` is 0 for static (1 phase), 1 for 1:2 (2 phases), 2 for 1:3 (3 phases) and 3 for 1:4 (4 phases). The last phase index equals the code. Each tick pulse moves `phase_o` on by one in the cycle after the tick, and it goes from the last phase back to 0.
- R3: `sync_oe_o` rises in the cycle after a tick that moves the phase into the last phase. It falls in the cycle after the tick that leaves it, so it is held for exactly one tick period. Without a tick, a mode change or a realignment, `phase_o` and `sync_oe_o` keep their values.
- R4: `sync_oe_o` is never high while `phase_o` differs from the last phase of the active mode.
- R5: If the line reads low (`sync_in_n_i` = 0) in a cycle with no tick, while the block is not driving the line and is not in its last phase, then `phase_o` becomes the last phase in the next cycle and `sync_oe_o` stays 0. The following tick takes the phase to 0.
- R6: A low line has no effect when it coincides with a tick, or when the block is in its last phase. In those cases the phase and the drive follow R2 and R3 alone.
- R7: A change of `mux_mode_i` sets `phase_o` to 0 and `sync_oe_o` to 0 in the next cycle. This overrides a tick in the same cycle.
- R8: In static mode every tick re-enters the single phase 0. After the first tick, `sync_oe_o` therefore stays high continuously while `phase_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse marking a backplane phase boundary |
| mux_mode_i | input | 2 | Multiplex ratio code (0 static, 1 to 3 for 1:2 to 1:4) |
| sync_in_n_i | input | 1 | Read-back of the shared sync line, low when asserted |
| sync_oe_o | output | 1 | Pull-down enable for the shared sync line, high to assert |
| phase_o | output | 2 | Current backplane phase index |

## Verification
The assertions assume that tick pulses are separated by at least one idle cycle. They also assume that the sync line read-back is already synchronous to `clk`, because realignment is judged only in tick-free cycles. The bench always follows a tick with an idle cycle. It drives the line low for a single idle cycle at a time, except for one deliberate collision of a low line with a tick. It sweeps every multiplex mode through every starting phase for realignment. Mode changes always pass through a different code, so that each change is seen as a real change.

// File: rtl/bpsync_pkg.sv
// Package: shared widths, multiplex mode codes and the last-phase mapping.
// Assumes the phase count of a mode is its code plus one.
package bpsync_pkg;
    localparam int MODE_W  = 2;
    localparam int PHASE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MUX_STATIC = 2'd0,
        MUX_1TO2   = 2'd1,
        MUX_1TO3   = 2'd2,
        MUX_1TO4   = 2'd3
    } mux_mode_e;

    // Index of the final active backplane phase for a mode code.
    function automatic logic [PHASE_W-1:0] last_phase(input logic [MODE_W-1:0] mode);
        return PHASE_W'(mode);
    endfunction
endpackage

// File: rtl/bpsync_mode_track.sv
// Mode tracker: registers the multiplex code and flags any change.
// Assumes the mode input is synchronous to clk; reset captures the input
// so that leaving reset is not seen as a mode change.
module bpsync_mode_track #(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              change_o
);
    logic [MODE_W-1:0] mode_q;

    // Hold the active multiplex code.
    always_ff @(posedge clk) begin
        mode_q <= mode_i;
    end

    // A differing input code is a change in this cycle.
    always_comb begin
        change_o = rst_n && (mode_i != mode_q);
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/bpsync_phase_ctr.sv
// Phase counter: steps the backplane phase on each tick and wraps after the
// last phase. Clear has priority, then tick, then realignment.
// Assumes the last-phase input is stable except when clear is raised.
module bpsync_phase_ctr #(
    parameter int PHASE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               tick_i,
    input  logic               realign_i,
    input  logic [PHASE_W-1:0] last_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               enter_last_o
);
    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] phase_step;

    // Next phase after a tick, wrapping at or past the last phase.
    always_comb begin
        if (phase_q >= last_i) phase_step = '0;
        else                   phase_step = phase_q + 1'b1;
    end

    // Flag a tick that lands in the last phase.
    always_comb begin
        enter_last_o = tick_i && !clear_i && (phase_step == last_i);
    end

    // Phase register update with its priority order.
    always_ff @(posedge clk) begin
        if (!rst_n)         phase_q <= '0;
        else if (clear_i)   phase_q <= '0;
        else if (tick_i)    phase_q <= phase_step;
        else if (realign_i) phase_q <= last_i;
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/bpsync_line_ctl.sv
// Line control: drives the shared sync line during the last phase and
// watches it otherwise, requesting realignment when another device asserts.
// Assumes the read-back is synchronous and ticks are at least two cycles apart.
module bpsync_line_ctl #(
    parameter int PHASE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               tick_i,
    input  logic               enter_last_i,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic [PHASE_W-1:0] last_i,
    input  logic               sync_in_n_i,
    output logic               sync_oe_o,
    output logic               realign_o
);
    logic oe_q;

    // Pull-down enable: set on entering the last phase, cleared by any other tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       oe_q <= 1'b0;
        else if (clear_i) oe_q <= 1'b0;
        else if (tick_i)  oe_q <= enter_last_i;
    end

    // Foreign assertion seen while monitoring and out of step.
    always_comb begin
        realign_o = !clear_i && !tick_i && !oe_q && !sync_in_n_i
                    && (phase_i != last_i);
    end

    assign sync_oe_o = oe_q;
endmodule

// File: rtl/bpsync_seq.sv
// Top: backplane sync sequencer for one device in a cascade sharing a
// wired-AND sync line. Ties mode tracking, phase counting and line control.
// Assumes a synchronous line read-back and one idle cycle between ticks.
module bpsync_seq #(
    parameter int MODE_W  = bpsync_pkg::MODE_W,
    parameter int PHASE_W = bpsync_pkg::PHASE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [MODE_W-1:0]  mux_mode_i,
    input  logic               sync_in_n_i,
    output logic               sync_oe_o,
    output logic [PHASE_W-1:0] phase_o
);
    logic [MODE_W-1:0]  mode_q;
    logic               mode_chg;
    logic [PHASE_W-1:0] last_ph;
    logic [PHASE_W-1:0] phase_w;
    logic               enter_last;
    logic               realign;

    bpsync_mode_track #(.MODE_W(MODE_W)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mux_mode_i),
        .mode_o   (mode_q),
        .change_o (mode_chg)
    );

    // Last active phase for the registered mode.
    always_comb begin
        last_ph = bpsync_pkg::last_phase(mode_q);
    end

    bpsync_phase_ctr #(.PHASE_W(PHASE_W)) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (mode_chg),
        .tick_i       (tick_i),
        .realign_i    (realign),
        .last_i       (last_ph),
        .phase_o      (phase_w),
        .enter_last_o (enter_last)
    );

    bpsync_line_ctl #(.PHASE_W(PHASE_W)) u_line (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (mode_chg),
        .tick_i       (tick_i),
        .enter_last_i (enter_last),
        .phase_i      (phase_w),
        .last_i       (last_ph),
        .sync_in_n_i  (sync_in_n_i),
        .sync_oe_o    (sync_oe_o),
        .realign_o    (realign)
    );

    assign phase_o = phase_w;
endmodule

// File: rtl/bpsync_seq_chk.sv
// Checker: temporal properties of the sequencer, bound to the top module.
// Assumes ticks are separated by an idle cycle and mode_q is the registered mode.
module bpsync_seq_chk #(
    parameter int MODE_W  = 2,
    parameter int PHASE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_i,
    input logic [MODE_W-1:0]  mux_mode_i,
    input logic               sync_in_n_i,
    input logic               sync_oe_o,
    input logic [PHASE_W-1:0] phase_o,
    input logic [MODE_W-1:0]  mode_q
);
    a_r2_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        PHASE_W'(phase_o) <= PHASE_W'(mode_q));

    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && mux_mode_i == mode_q) |=>
        phase_o == (($past(phase_o) == PHASE_W'($past(mode_q))) ? '0 : $past(phase_o) + 1'b1));

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && sync_in_n_i && mux_mode_i == mode_q) |=>
        ($stable(phase_o) && $stable(sync_oe_o)));

    a_r4_oe_only_last: assert property (@(posedge clk) disable iff (!rst_n)
        sync_oe_o |-> phase_o == PHASE_W'(mode_q));

    a_r5_realign: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !sync_in_n_i && !sync_oe_o && phase_o != PHASE_W'(mode_q)
         && mux_mode_i == mode_q) |=>
        (phase_o == PHASE_W'($past(mode_q)) && !sync_oe_o));

    a_r7_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_mode_i != mode_q) |=> (phase_o == '0 && !sync_oe_o));

    a_r8_static_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && mode_q == '0 && mux_mode_i == mode_q) |=> sync_oe_o);
endmodule

bind bpsync_seq bpsync_seq_chk #(.MODE_W(MODE_W), .PHASE_W(PHASE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .mux_mode_i  (mux_mode_i),
    .sync_in_n_i (sync_in_n_i),
    .sync_oe_o   (sync_oe_o),
    .phase_o     (phase_o),
    .mode_q      (mode_q)
);

// File: tb/test_bpsync_seq.sv
module test_bpsync_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [1:0] mux_mode_i = 2'd3;
    logic       sync_in_n_i = 1'b1;
    logic       sync_oe_o;
    logic [1:0] phase_o;

    int n_checks = 0;
    int n_fail = 0;

    bpsync_seq i_bpsync_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .mux_mode_i  (mux_mode_i),
        .sync_in_n_i (sync_in_n_i),
        .sync_oe_o   (sync_oe_o),
        .phase_o     (phase_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick_once();
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
    endtask

    // Change to mode m via another code, then check the cleared state (R7).
    task automatic set_mode(input int m);
        @(negedge clk) mux_mode_i = 2'((m + 1) % 4);
        @(negedge clk) mux_mode_i = 2'(m);
        @(negedge clk);
        check("R7 phase after mode change", int'(phase_o), 0);
        check("R7 drive after mode change", int'(sync_oe_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 phase after reset", int'(phase_o), 0);
        check("R1 drive after reset", int'(sync_oe_o), 0);

        for (int m = 0; m < 4; m++) begin
            int n;
            n = m + 1;
            // R2/R3/R8: free-running sweep over three full cycles.
            set_mode(m);
            for (int k = 1; k <= 3 * n; k++) begin
                tick_once();
                check("R2 phase step", int'(phase_o), k % n);
                check("R3 drive in last phase", int'(sync_oe_o), (k % n == n - 1) ? 1 : 0);
                if (m == 0) check("R8 static drive held", int'(sync_oe_o), 1);
            end
            @(negedge clk);
            check("R3 phase stable without tick", int'(phase_o), 0);
            check("R3 drive stable without tick", int'(sync_oe_o), (m == 0) ? 1 : 0);

            // R5: realign from every phase before the last.
            for (int p = 0; p < n - 1; p++) begin
                set_mode(m);
                for (int j = 0; j < p; j++) tick_once();
                @(negedge clk) sync_in_n_i = 1'b0;
                @(negedge clk);
                check("R5 realigned phase", int'(phase_o), m);
                check("R5 no drive after realign", int'(sync_oe_o), 0);
                sync_in_n_i = 1'b1;
                tick_once();
                check("R5 wrap after realign", int'(phase_o), 0);
                check("R5 drive after wrap", int'(sync_oe_o), 0);
            end

            // R6: low line together with a tick is ignored.
            set_mode(m);
            @(negedge clk) begin tick_i = 1'b1; sync_in_n_i = 1'b0; end
            @(negedge clk) begin tick_i = 1'b0; sync_in_n_i = 1'b1; end
            check("R6 tick wins over line", int'(phase_o), 1 % n);
            check("R6 drive with tick", int'(sync_oe_o), ((1 % n) == m) ? 1 : 0);

            // R6: low line in own last phase is ignored.
            set_mode(m);
            for (int j = 0; j < m; j++) tick_once();
            @(negedge clk) sync_in_n_i = 1'b0;
            @(negedge clk) sync_in_n_i = 1'b1;
            check("R6 last phase kept", int'(phase_o), m);
            check("R6 own drive kept", int'(sync_oe_o), (m > 0) ? 1 : 0);

            // R7: mode change beats a tick in the same cycle.
            set_mode(m);
            tick_once();
            @(negedge clk) begin tick_i = 1'b1; mux_mode_i = 2'((m + 1) % 4); end
            @(negedge clk) tick_i = 1'b0;
            check("R7 change beats tick phase", int'(phase_o), 0);
            check("R7 change beats tick drive", int'(sync_oe_o), 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule